// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block watches the four active-low control strobes and the multiplexed address of a page-mode dynamic memory. It samples them on a fast system clock and decides what kind of memory cycle a controller is running. Every strobe is registered once and compared with its previous sample to find edges. A decode state machine then works out the cycle type from the order of those edges alone: normal read, early write, late write, read-modify-write, refresh of a given row with no column strobe, refresh with the column strobe first (internal row counter), or hidden refresh. Analog timing limits are not checked.

Each decoded cycle is reported as a single-cycle event that carries a kind code, the row and the column. An orderings the rules cannot resolve raises a one-cycle error pulse instead. A small behavioural store, indexed by the low bits of the row and column, backs reads and writes. The block drives a 4-bit read-data output with a separate output-enable, so it can serve as a memory model when controller logic is tested.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset the output-enable is low, no event or error is reported, and the refresh row counter is 0.
- R2: A row-strobe fall while the column strobe is high latches the address as the row. If the row strobe then rises with no column strobe fall in that window, a refresh-by-row event (kind 5) is reported with the latched row and column 0, and the output stays off.
- R3: A row-strobe fall while the column strobe is already low, with no read data on the bus, reports a counter refresh event (kind 6) whose row is the internal counter and whose column is 0. The counter then advances by one, modulo 1024.
- R4: With write-enable high, a read event (kind 1) is reported at the later of the column-strobe fall and the output-enable fall. It carries the row and the column, and the stored data for that location is driven with output-enable high in the same cycle as the event.
- R5: If write-enable is already low when the column strobe falls, an early write event (kind 2) is reported, the data input is stored, and the output-enable stays low.
- R6: A write-enable fall after the column strobe, with the output-enable input high and no read done in that column cycle, reports a late write event (kind 3) and stores the data input sampled with that fall.
- R7: A write-enable fall after a read in the same column cycle, with the output-enable input raised again, reports a read-modify-write event (kind 4), stores the new data and turns the output off.
- R8: A row-strobe fall while the column strobe stays low and read data is on the bus reports a hidden refresh event (kind 7) with the counter row. The counter advances and the read data stays driven.
- R9: The output turns off when the column strobe rises or the output-enable input goes high, and it is off whenever both strobes are high. A new output-enable fall in the same column cycle after a read drives the same data again and reports no event.
- R10: The error output pulses, with no event and no store, when write-enable falls in the same sample as the column strobe, or falls while the output-enable input is low during a column cycle.
- R11: Within one row-strobe window, each column-strobe cycle is decoded on its own against the latched row. The row strobe rising after any column cycle reports no event.
- R12: Events, error pulses and changes of the output-enable appear exactly two clock edges after the strobe change that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | 10 | Multiplexed row/column address |
| dq_i | input | 4 | Write data |
| dq_o | output | 4 | Read data |
| dq_oe_o | output | 1 | Read data driven on the bus |
| evt_valid_o | output | 1 | One-cycle decoded-cycle pulse |
| evt_kind_o | output | 3 | Kind code of the decoded cycle |
| evt_row_o | output | 10 | Row of the decoded cycle |
| evt_col_o | output | 10 | Column of the decoded cycle (0 for refresh) |
| err_o | output | 1 | One-cycle pulse for an unresolvable ordering |

## Verification
Every result sits two clock edges after the input change that causes it: one edge registers the strobes, and the next registers the decision, the event fields and the bus state. The bench changes one strobe just after a falling clock edge and notes the cycle count. It logs each event or error with the cycle it was seen in, and requires that gap to be exactly two. Bus values are read only after four cycles with the inputs still, so every register on the path has settled.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int unsigned STB_W   = 4;
  localparam int unsigned STB_RAS = 0;
  localparam int unsigned STB_CAS = 1;
  localparam int unsigned STB_WE  = 2;
  localparam int unsigned STB_OE  = 3;

  typedef enum logic [2:0] {
    EVK_NONE     = 3'd0,
    EVK_READ     = 3'd1,
    EVK_EARLY_WR = 3'd2,
    EVK_LATE_WR  = 3'd3,
    EVK_RMW      = 3'd4,
    EVK_RAS_ONLY = 3'd5,
    EVK_CBR      = 3'd6,
    EVK_HIDDEN   = 3'd7
  } evt_kind_e;

  // IDLE: both strobes high; HOLD: row high, column low
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_REF  = 3'd3,
    ST_HOLD = 3'd4
  } dec_state_e;
endpackage

// File: rtl/drc_sampler.sv
module drc_sampler
  import drc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STB_W-1:0]  stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [STB_W-1:0]  stb_o,
  output logic [STB_W-1:0]  fall_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] din_o
);
  logic [STB_W-1:0] cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '1;
      prev_q <= '1;
      addr_o <= '0;
      din_o  <= '0;
    end else begin
      cur_q  <= stb_i;
      prev_q <= cur_q;
      addr_o <= addr_i;
      din_o  <= din_i;
    end
  end

  for (genvar i = 0; i < STB_W; i++) begin : g_edge
    assign fall_o[i] = prev_q[i] & ~cur_q[i];
  end

  assign stb_o = cur_q;
endmodule

// File: rtl/drc_store.sv
module drc_store #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/drc_fsm.sv
module drc_fsm
  import drc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned ROW_IDX_W = 3,
  parameter int unsigned COL_IDX_W = 3,
  localparam int unsigned IDX_W    = ROW_IDX_W + COL_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STB_W-1:0]  stb_i,
  input  logic [STB_W-1:0]  fall_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              evt_valid_o,
  output logic [2:0]        evt_kind_o,
  output logic [ADDR_W-1:0] evt_row_o,
  output logic [ADDR_W-1:0] evt_col_o,
  output logic              err_o
);
  dec_state_e        st_q, st_n;
  logic [ADDR_W-1:0] row_q, row_n, col_q, col_n, ref_q, ref_n;
  logic              rd_done_q, rd_done_n, acc_q, acc_n, seen_q, seen_n;
  logic              drv_q, drv_n;
  logic [DATA_W-1:0] dout_q, dout_n;

  logic              ev_v, ev_err;
  evt_kind_e         ev_k;
  logic [ADDR_W-1:0] ev_row, ev_col;

  logic r, c, w, o;
  assign r = stb_i[STB_RAS];
  assign c = stb_i[STB_CAS];
  assign w = stb_i[STB_WE];
  assign o = stb_i[STB_OE];

  always_comb begin
    st_n      = st_q;
    row_n     = row_q;
    col_n     = col_q;
    ref_n     = ref_q;
    rd_done_n = rd_done_q;
    acc_n     = acc_q;
    seen_n    = seen_q;
    drv_n     = drv_q;
    dout_n    = dout_q;
    ev_v      = 1'b0;
    ev_err    = 1'b0;
    ev_k      = EVK_NONE;
    ev_row    = row_q;
    ev_col    = col_q;
    wr_en_o   = 1'b0;
    idx_o     = {row_q[ROW_IDX_W-1:0], col_q[COL_IDX_W-1:0]};

    case (st_q)
      ST_IDLE: begin
        if (fall_i[STB_RAS]) begin
          row_n  = addr_i;
          seen_n = 1'b0;
          st_n   = ST_ROW;
        end else if (fall_i[STB_CAS]) begin
          st_n = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (c) begin
          st_n = r ? ST_IDLE : ST_ROW;
          if (!r) begin
            row_n  = addr_i;
            seen_n = 1'b0;
          end
        end else if (fall_i[STB_RAS]) begin
          // column already low at row fall: refresh from the counter
          ev_v   = 1'b1;
          ev_k   = drv_q ? EVK_HIDDEN : EVK_CBR;
          ev_row = ref_q;
          ev_col = '0;
          ref_n  = ref_q + 1'b1;
          st_n   = ST_REF;
        end
      end
      ST_ROW: begin
        if (r) begin
          if (!seen_q) begin
            ev_v   = 1'b1;
            ev_k   = EVK_RAS_ONLY;
            ev_col = '0;
          end
          st_n = c ? ST_IDLE : ST_HOLD;
        end else if (!c) begin
          seen_n    = 1'b1;
          col_n     = addr_i;
          rd_done_n = 1'b0;
          acc_n     = 1'b0;
          st_n      = ST_COL;
          idx_o     = {row_q[ROW_IDX_W-1:0], addr_i[COL_IDX_W-1:0]};
          ev_col    = addr_i;
          if (fall_i[STB_WE]) begin
            ev_err = 1'b1;
            acc_n  = 1'b1;
          end else if (!w) begin
            ev_v    = 1'b1;
            ev_k    = EVK_EARLY_WR;
            wr_en_o = 1'b1;
            acc_n   = 1'b1;
          end else if (!o) begin
            ev_v      = 1'b1;
            ev_k      = EVK_READ;
            rd_done_n = 1'b1;
            drv_n     = 1'b1;
            dout_n    = rd_data_i;
          end
        end
      end
      ST_COL: begin
        if (c) begin
          st_n  = r ? ST_IDLE : ST_ROW;
          drv_n = 1'b0;
        end else if (r) begin
          st_n = ST_HOLD;
        end else if (fall_i[STB_WE] && !acc_q) begin
          acc_n = 1'b1;
          drv_n = 1'b0;
          if (!o) begin
            ev_err = 1'b1;
          end else begin
            wr_en_o = 1'b1;
            ev_v    = 1'b1;
            ev_k    = rd_done_q ? EVK_RMW : EVK_LATE_WR;
          end
        end else if (fall_i[STB_OE] && w && !acc_q) begin
          drv_n = 1'b1;
          if (!rd_done_q) begin
            ev_v      = 1'b1;
            ev_k      = EVK_READ;
            rd_done_n = 1'b1;
            dout_n    = rd_data_i;
          end
        end
      end
      ST_REF: begin
        if (r) st_n = c ? ST_IDLE : ST_HOLD;
      end
      default: st_n = ST_IDLE;
    endcase

    if (c || o) drv_n = 1'b0;
  end

  assign wr_data_o = din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      ref_q       <= '0;
      rd_done_q   <= 1'b0;
      acc_q       <= 1'b0;
      seen_q      <= 1'b0;
      drv_q       <= 1'b0;
      dout_q      <= '0;
      evt_valid_o <= 1'b0;
      evt_kind_o  <= EVK_NONE;
      evt_row_o   <= '0;
      evt_col_o   <= '0;
      err_o       <= 1'b0;
    end else begin
      st_q        <= st_n;
      row_q       <= row_n;
      col_q       <= col_n;
      ref_q       <= ref_n;
      rd_done_q   <= rd_done_n;
      acc_q       <= acc_n;
      seen_q      <= seen_n;
      drv_q       <= drv_n;
      dout_q      <= dout_n;
      evt_valid_o <= ev_v;
      evt_kind_o  <= ev_k;
      evt_row_o   <= ev_row;
      evt_col_o   <= ev_col;
      err_o       <= ev_err;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = drv_q;
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import drc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned ROW_IDX_W = 3,
  parameter int unsigned COL_IDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              evt_valid_o,
  output logic [2:0]        evt_kind_o,
  output logic [ADDR_W-1:0] evt_row_o,
  output logic [ADDR_W-1:0] evt_col_o,
  output logic              err_o
);
  localparam int unsigned IDX_W = ROW_IDX_W + COL_IDX_W;

  logic [STB_W-1:0]  strb_cur, strb_fall;
  logic [ADDR_W-1:0] addr_cur;
  logic [DATA_W-1:0] din_cur, rd_data, wr_data;
  logic [IDX_W-1:0]  mem_idx;
  logic              wr_en;

  drc_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  ({oe_n_i, we_n_i, cas_n_i, ras_n_i}),
    .addr_i (addr_i),
    .din_i  (dq_i),
    .stb_o  (strb_cur),
    .fall_o (strb_fall),
    .addr_o (addr_cur),
    .din_o  (din_cur)
  );

  drc_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ROW_IDX_W(ROW_IDX_W), .COL_IDX_W(COL_IDX_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (strb_cur),
    .fall_i      (strb_fall),
    .addr_i      (addr_cur),
    .din_i       (din_cur),
    .rd_data_i   (rd_data),
    .wr_en_o     (wr_en),
    .idx_o       (mem_idx),
    .wr_data_o   (wr_data),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o),
    .evt_valid_o (evt_valid_o),
    .evt_kind_o  (evt_kind_o),
    .evt_row_o   (evt_row_o),
    .evt_col_o   (evt_col_o),
    .err_o       (err_o)
  );

  drc_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (mem_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (mem_idx),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/drc_checker.sv
module drc_checker
  import drc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STB_W-1:0]  strb_cur,
  input logic              dq_oe_o,
  input logic              evt_valid_o,
  input logic [2:0]        evt_kind_o,
  input logic [ADDR_W-1:0] evt_row_o,
  input logic              err_o
);
  logic              ref_seen_q;
  logic [ADDR_W-1:0] ref_last_q;
  logic              is_ref;

  assign is_ref = evt_valid_o &&
                  (evt_kind_o == EVK_CBR || evt_kind_o == EVK_HIDDEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_seen_q <= 1'b0;
      ref_last_q <= '0;
    end else if (is_ref) begin
      ref_seen_q <= 1'b1;
      ref_last_q <= evt_row_o;
    end
  end

  assert_refresh_rows_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref |-> evt_row_o == (ref_seen_q ? ADDR_W'(ref_last_q + 1'b1) : '0));

  assert_read_drives_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EVK_READ) |-> dq_oe_o);

  assert_early_write_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EVK_EARLY_WR) |-> !dq_oe_o);

  assert_rmw_releases_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EVK_RMW) |-> !dq_oe_o);

  assert_hidden_keeps_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EVK_HIDDEN) |-> dq_oe_o && $past(dq_oe_o));

  assert_idle_bus_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_cur[STB_RAS] && strb_cur[STB_CAS]) |=> !dq_oe_o);

  assert_err_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_valid_o && err_o));
endmodule

bind dram_cycle_decoder drc_checker #(.ADDR_W(ADDR_W)) u_drc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .strb_cur    (strb_cur),
  .dq_oe_o     (dq_oe_o),
  .evt_valid_o (evt_valid_o),
  .evt_kind_o  (evt_kind_o),
  .evt_row_o   (evt_row_o),
  .err_o       (err_o)
);

// File: tb/tb_dram_cycle_decoder.sv
`timescale 1ns/100ps
module tb_dram_cycle_decoder;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 4;
  localparam int unsigned LOG_N = 256;
  localparam logic [3:0] K_ERR = 4'h8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_r = 1'b1, s_c = 1'b1, s_w = 1'b1, s_o = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o, evt_valid_o, err_o;
  logic [2:0] evt_kind_o;
  logic [AW-1:0] evt_row_o, evt_col_o;

  int vectors = 0, fails = 0, cyc = 0, drv_cyc = 0;
  int n_log = 0, rp = 0;
  logic [3:0]    log_kind [LOG_N];
  logic [AW-1:0] log_row  [LOG_N];
  logic [AW-1:0] log_col  [LOG_N];
  int            log_lat  [LOG_N];
  bit finished = 0;

  always #2.5 clk = ~clk;

  dram_cycle_decoder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ras_n_i(s_r), .cas_n_i(s_c), .we_n_i(s_w), .oe_n_i(s_o),
    .addr_i(addr), .dq_i(din), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .evt_valid_o(evt_valid_o), .evt_kind_o(evt_kind_o),
    .evt_row_o(evt_row_o), .evt_col_o(evt_col_o), .err_o(err_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (rst_n && (evt_valid_o || err_o) && n_log < LOG_N) begin
      log_kind[n_log] = evt_valid_o ? {1'b0, evt_kind_o} : K_ERR;
      log_row[n_log]  = evt_row_o;
      log_col[n_log]  = evt_col_o;
      log_lat[n_log]  = cyc - drv_cyc;
      n_log++;
    end
  end

  function automatic logic [AW-1:0] row_a(input int r);
    return AW'(r * 73);
  endfunction
  function automatic logic [AW-1:0] col_a(input int c);
    return AW'(c * 129);
  endfunction
  function automatic logic [DW-1:0] pat(input int r, input int c);
    return DW'(r * 3 + c * 5 + 1);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic go();
    drv_cyc = cyc;
    repeat (4) @(negedge clk);
  endtask
  task automatic ras(input logic v); s_r = v; go(); endtask
  task automatic cas(input logic v); s_c = v; go(); endtask
  task automatic we(input logic v);  s_w = v; go(); endtask
  task automatic oe(input logic v);  s_o = v; go(); endtask

  task automatic expect_evt(input logic [3:0] k, input logic [AW-1:0] row,
                            input logic [AW-1:0] col, input string req);
    vectors++;
    if (rp >= n_log) begin
      fails++;
      $display("FAIL %s: no event, expected kind %0d row %0d col %0d", req, k, row, col);
    end else begin
      if (log_kind[rp] != k || log_row[rp] != row || log_col[rp] != col) begin
        fails++;
        $display("FAIL %s: kind/row/col %0d/%0d/%0d expected %0d/%0d/%0d", req,
                 log_kind[rp], log_row[rp], log_col[rp], k, row, col);
      end
      // R12: two edges from drive to registered event
      vectors++;
      if (log_lat[rp] != 2) begin
        fails++;
        $display("FAIL R12 (%s): latency %0d expected 2", req, log_lat[rp]);
      end
      rp++;
    end
  endtask

  task automatic expect_none(input string req);
    vectors++;
    if (rp != n_log) begin
      fails++;
      $display("FAIL %s: %0d unexpected events, expected 0 (first kind %0d)",
               req, n_log - rp, log_kind[rp]);
      rp = n_log;
    end
  endtask

  task automatic expect_bus(input logic oe_exp, input logic [DW-1:0] d, input string req);
    vectors++;
    if (dq_oe_o !== oe_exp || (oe_exp && dq_o !== d)) begin
      fails++;
      $display("FAIL %s: bus oe=%b data=%h expected oe=%b data=%h", req, dq_oe_o, dq_o, oe_exp, d);
    end
  endtask

  task automatic read_at(input int r, input int c, input logic [DW-1:0] d, input string req);
    addr = row_a(r); ras(1'b0);
    oe(1'b0);
    addr = col_a(c); cas(1'b0);
    expect_evt({1'b0, 3'd1}, row_a(r), col_a(c), req);
    expect_bus(1'b1, d, req);
    cas(1'b1);
    expect_bus(1'b0, '0, "R9 cas rise");
    ras(1'b1); oe(1'b1);
    expect_none(req);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL R12: watchdog expired, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    vectors++;
    if (dq_oe_o !== 1'b0 || evt_valid_o !== 1'b0 || err_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: oe=%b valid=%b err=%b expected 0/0/0", dq_oe_o, evt_valid_o, err_o);
    end
    expect_none("R1");

    // R3 counter refresh, back to back, counter starts at 0
    cas(1'b0); expect_none("R3 cas first");
    ras(1'b0); expect_evt({1'b0, 3'd6}, 10'd0, '0, "R3 first");
    ras(1'b1);
    ras(1'b0); expect_evt({1'b0, 3'd6}, 10'd1, '0, "R3 second");
    expect_bus(1'b0, '0, "R3 bus off");
    ras(1'b1); cas(1'b1);
    expect_bus(1'b0, '0, "R9 both high");

    // R2 refresh by row
    addr = 10'h2A5; ras(1'b0); expect_none("R2 open");
    addr = 10'h013; ras(1'b1);
    expect_evt({1'b0, 3'd5}, 10'h2A5, '0, "R2");
    expect_bus(1'b0, '0, "R2 bus off");

    // R5/R11 early-write sweep, page mode per row
    for (int r = 0; r < 8; r++) begin
      addr = row_a(r); ras(1'b0);
      we(1'b0);
      for (int c = 0; c < 8; c++) begin
        addr = col_a(c); din = pat(r, c); cas(1'b0);
        expect_evt({1'b0, 3'd2}, row_a(r), col_a(c), "R5 early write");
        expect_bus(1'b0, '0, "R5 quiet");
        cas(1'b1);
      end
      we(1'b1);
      ras(1'b1); expect_none("R11 no event at row close");
    end

    // R4/R11 read sweep, page mode per row
    for (int r = 0; r < 8; r++) begin
      addr = row_a(r); ras(1'b0);
      oe(1'b0);
      for (int c = 0; c < 8; c++) begin
        addr = col_a(c); cas(1'b0);
        expect_evt({1'b0, 3'd1}, row_a(r), col_a(c), "R4 read");
        expect_bus(1'b1, pat(r, c), "R4 data");
        cas(1'b1);
        expect_bus(1'b0, '0, "R9 cas rise");
      end
      ras(1'b1); oe(1'b1);
      expect_none("R11 no event at row close");
    end

    // R4 output-enable last, R9 off and redrive, R8 hidden refresh
    addr = row_a(1); ras(1'b0);
    addr = col_a(2); cas(1'b0);
    expect_none("R4 cas first, oe high");
    oe(1'b0);
    expect_evt({1'b0, 3'd1}, row_a(1), col_a(2), "R4 oe last");
    expect_bus(1'b1, pat(1, 2), "R4 oe last data");
    oe(1'b1); expect_bus(1'b0, '0, "R9 oe rise");
    oe(1'b0); expect_bus(1'b1, pat(1, 2), "R9 redrive");
    expect_none("R9 redrive no event");
    ras(1'b1); expect_bus(1'b1, pat(1, 2), "R8 row high keeps data");
    ras(1'b0);
    expect_evt({1'b0, 3'd7}, 10'd2, '0, "R8 hidden");
    expect_bus(1'b1, pat(1, 2), "R8 data held");
    ras(1'b1); cas(1'b1);
    expect_bus(1'b0, '0, "R9 both high");
    oe(1'b1); expect_none("R8 close");

    // R6 late write
    addr = row_a(3); ras(1'b0);
    addr = col_a(4); cas(1'b0);
    din = 4'hA; we(1'b0);
    expect_evt({1'b0, 3'd3}, row_a(3), col_a(4), "R6 late write");
    expect_bus(1'b0, '0, "R6 bus off");
    we(1'b1); cas(1'b1); ras(1'b1);
    expect_none("R6 close");

    // R7 read-modify-write
    addr = row_a(5); ras(1'b0);
    addr = col_a(6); cas(1'b0);
    oe(1'b0);
    expect_evt({1'b0, 3'd1}, row_a(5), col_a(6), "R7 read part");
    expect_bus(1'b1, pat(5, 6), "R7 old data");
    oe(1'b1);
    din = 4'h5; we(1'b0);
    expect_evt({1'b0, 3'd4}, row_a(5), col_a(6), "R7 rmw");
    expect_bus(1'b0, '0, "R7 bus off");
    we(1'b1); cas(1'b1); ras(1'b1);
    expect_none("R7 close");

    // R10 write-enable fall with output-enable low
    addr = row_a(6); ras(1'b0);
    oe(1'b0);
    addr = col_a(1); cas(1'b0);
    expect_evt({1'b0, 3'd1}, row_a(6), col_a(1), "R10 read part");
    din = 4'hC; we(1'b0);
    expect_evt(K_ERR, row_a(6), col_a(1), "R10 oe low");
    expect_bus(1'b0, '0, "R10 bus off");
    we(1'b1); cas(1'b1); ras(1'b1); oe(1'b1);
    expect_none("R10 close");

    // R10 write-enable and column strobe in the same sample
    addr = row_a(6); ras(1'b0);
    addr = col_a(3); din = 4'h3; s_c = 1'b0; s_w = 1'b0; go();
    expect_evt(K_ERR, row_a(6), col_a(3), "R10 coincident");
    we(1'b1); cas(1'b1); ras(1'b1);
    expect_none("R10 close");

    // Stored results
    read_at(3, 4, 4'hA, "R6 stored");
    read_at(5, 6, 4'h5, "R7 stored");
    read_at(6, 1, pat(6, 1), "R10 no store oe low");
    read_at(6, 3, pat(6, 3), "R10 no store coincident");

    // R3 counter continues after the hidden refresh
    cas(1'b0); ras(1'b0);
    expect_evt({1'b0, 3'd6}, 10'd3, '0, "R3 after hidden");
    ras(1'b1); cas(1'b1);
    expect_none("R3 close");

    summary();
  end
endmodule